// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a vector of request lines from I/O devices and turns them into a single interrupt line for the processor. Each line runs through a two-flop synchronizer and is then captured in a pending register. The pending bit stays set until the processor acknowledges that source. A mask register decides which pending sources may compete. A global enable decides whether any of them reach the processor. Among the sources that may compete, the lowest-numbered one wins.

When the processor acknowledges, the controller returns the number of the winning source and the entry address of its handler. The address is a programmable base plus the source number times sixteen. The controller also marks that source as in service. While a source is in service, that source and every lower-priority source are held back. Only a strictly higher-priority source can interrupt the running handler. An end-of-interrupt write retires the highest-priority source that is in service, and the controller re-evaluates its pending requests on the next cycle.

Configuration uses a single-cycle write port with a 2-bit select:

| Select | Effect of the write |
|--------|---------------------|
| 0 | Loads the mask from `cfg_wdata[NUM_SRC-1:0]`; a 1 enables that source. |
| 1 | Loads the handler base address. |
| 2 | Loads the global enable from `cfg_wdata[0]`. |
| 3 | End of interrupt; the data is ignored. |

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: `cpu_irq_o`, `ack_id_o`, `ack_vec_o`, the mask (every source disabled), the handler base, the global enable and the in-service state.
- R2: Take a request line that rises between two clock edges while it is unmasked, enabled and not blocked. `cpu_irq_o` stays low through the second rising edge after the rise and is high after the third (two synchronizer flops, then the pending register).
- R3: A pending request whose mask bit is 0 does not assert `cpu_irq_o`. It stays pending, and it is presented once its mask bit is written to 1.
- R4: When several eligible requests are pending, the one with the lowest source number is presented (source 0 has the highest priority).
- R5: If `ack_i` is high on a rising edge while `cpu_irq_o` is high, then after that edge `ack_id_o` holds the winning source number. `ack_vec_o` holds base + (source number << 4). The pending bit of that source is cleared.
- R6: While the global enable (select 2, bit 0) is 0, `cpu_irq_o` stays low and requests stay pending. They are presented once the enable is written to 1.
- R7: While a source is in service, requests from that source and from lower-priority sources do not assert `cpu_irq_o`.
- R8: A request from a source of strictly higher priority than every in-service source asserts `cpu_irq_o` and can be acknowledged over the running handler.
- R9: An end-of-interrupt write (select 3) clears only the highest-priority in-service bit. The pending requests are re-evaluated against the remaining in-service bits in the cycle after the write.
- R10: An `ack_i` pulse while `cpu_irq_o` is low leaves `ack_id_o`, `ack_vec_o` and the in-service state unchanged.
- R11: A request pulse that lasts a single clock is held as pending and is presented later, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | NUM_SRC | Asynchronous request lines, bit 0 highest priority |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mask, 1 base, 2 enable, 3 end of interrupt |
| cfg_wdata | input | ADDR_W | Write data |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| cpu_irq_o | output | 1 | Interrupt request to the processor |
| ack_id_o | output | $clog2(NUM_SRC) | Number of the acknowledged source |
| ack_vec_o | output | ADDR_W | Handler entry address of the acknowledged source |

## Verification
The hardest state to reach from the ports is nesting two levels deep. It needs a lower-priority handler in service, a higher-priority handler acknowledged over it, and both an equal-priority and a lower-priority request waiting behind them. The stimulus builds this state one step at a time. It first acknowledges source 3, then pulses source 5 and source 3 again and confirms that neither raises the interrupt. It then acknowledges source 1 over source 3. Two end-of-interrupt writes then unwind the stack. The first must leave the interrupt low, and the second must release source 3 and then source 5 in priority order, in the cycle right after the write.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared definitions for the prioritized interrupt controller.
// Assumes a 2-bit configuration select on the register port.
package irq_pkg;
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_BASE = 2'd1,
        SEL_EN   = 2'd2,
        SEL_EOI  = 2'd3
    } cfg_sel_e;

    localparam int unsigned VEC_SHIFT = 4;
endpackage

// File: rtl/irq_sync.sv
// Module irq_sync
// Two-flop synchronizer for each request line.
// Assumes each line is level-based and may change at any time.
module irq_sync #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end

        assign sync_o[g] = stab_q;

        // R2
        sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stab_q) |-> $past(async_i[g], 2));
    end
endmodule

// File: rtl/irq_pending.sv
// Module irq_pending
// Pending register for the requests.
// A synchronized high level sets a bit. Only an acknowledge clears it.
// Assumes clr_i carries at most the acknowledged source.
module irq_pending #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    // Latch levels and drop acknowledged bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | req_i;
    end

    assign pend_o = pend_q;

    // R11
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend_q) & ~pend_q)) |-> (|$past(clr_i)));
endmodule

// File: rtl/irq_arbiter.sv
// Module irq_arbiter
// Fixed-priority selection; index 0 is the most urgent.
// The highest-priority in-service bit blocks its own index and every higher index.
// Purely combinational.
module irq_arbiter #(
    parameter int unsigned N    = 8,
    parameter int unsigned ID_W = $clog2(N)
) (
    input  logic [N-1:0]    cand_i,
    input  logic [N-1:0]    isr_i,
    output logic            win_vld_o,
    output logic [ID_W-1:0] win_id_o
);
    // Scan upward and stop at the first in-service level.
    always_comb begin
        logic blocked;
        blocked   = 1'b0;
        win_vld_o = 1'b0;
        win_id_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (isr_i[i]) begin
                blocked = 1'b1;
            end else if (!blocked && !win_vld_o && cand_i[i]) begin
                win_vld_o = 1'b1;
                win_id_o  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_inservice.sv
// Module irq_inservice
// In-service register. An acknowledge sets a bit.
// An end of interrupt clears the lowest-index set bit.
// Assumes set_i is one-hot or zero.
module irq_inservice #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         eoi_i,
    output logic [N-1:0] isr_o
);
    logic [N-1:0] isr_q;
    logic [N-1:0] top_bit;

    // Isolate the highest-priority bit in service.
    assign top_bit = isr_q & (~isr_q + N'(1));

    // Apply the end-of-interrupt clear, then the acknowledge set.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~(eoi_i ? top_bit : '0)) | set_i;
    end

    assign isr_o = isr_q;

    // R9
    eoi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(isr_q) & ~isr_q) <= 1);
    // R9
    eoi_only_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(isr_q) & ~isr_q)) |-> $past(eoi_i));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module prio_irq_ctrl
// Top level of the prioritized interrupt controller: synchronizers, pending
// register, mask, global enable, fixed-priority arbiter, in-service nesting
// and the acknowledge outputs (source number and handler address).
// Assumes ack_i and cfg_we are synchronous to clk.
module prio_irq_ctrl #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               ack_i,
    output logic               cpu_irq_o,
    output logic [ID_W-1:0]    ack_id_o,
    output logic [ADDR_W-1:0]  ack_vec_o
);
    import irq_pkg::*;

    logic [NUM_SRC-1:0] req_s;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] isr;
    logic [NUM_SRC-1:0] mask_q;
    logic [ADDR_W-1:0]  base_q;
    logic               en_q;
    logic               win_vld;
    logic [ID_W-1:0]    win_id;
    logic               ack_fire;
    logic [NUM_SRC-1:0] ack_onehot;
    logic               eoi;
    logic [ID_W-1:0]    ack_id_q;
    logic [ADDR_W-1:0]  ack_vec_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^cfg_wdata[ADDR_W-1:NUM_SRC];

    irq_sync #(.N(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_req_i),
        .sync_o  (req_s)
    );

    irq_pending #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_s),
        .clr_i  (ack_onehot),
        .pend_o (pend)
    );

    irq_arbiter #(.N(NUM_SRC), .ID_W(ID_W)) u_arb (
        .cand_i    (pend & mask_q),
        .isr_i     (isr),
        .win_vld_o (win_vld),
        .win_id_o  (win_id)
    );

    irq_inservice #(.N(NUM_SRC)) u_isr (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ack_onehot),
        .eoi_i (eoi),
        .isr_o (isr)
    );

    assign cpu_irq_o  = en_q & win_vld;
    assign ack_fire   = ack_i & cpu_irq_o;
    assign ack_onehot = ack_fire ? (NUM_SRC'(1) << win_id) : '0;
    assign eoi        = cfg_we && (cfg_sel == SEL_EOI);

    // Configuration registers written through the select port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            base_q <= '0;
            en_q   <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_MASK: mask_q <= cfg_wdata[NUM_SRC-1:0];
                SEL_BASE: base_q <= cfg_wdata;
                SEL_EN:   en_q   <= cfg_wdata[0];
                default:  ;
            endcase
        end
    end

    // Capture the source number and handler address on an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_id_q  <= '0;
            ack_vec_q <= '0;
        end else if (ack_fire) begin
            ack_id_q  <= win_id;
            ack_vec_q <= base_q + (ADDR_W'(win_id) << VEC_SHIFT);
        end
    end

    assign ack_id_o  = ack_id_q;
    assign ack_vec_o = ack_vec_q;

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> (mask_q[win_id] && pend[win_id]));
    // R6
    global_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !cpu_irq_o);
    // R7
    nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> ((isr & (~({NUM_SRC{1'b1}} << win_id) | (NUM_SRC'(1) << win_id))) == '0));
    // R5
    vec_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_fire) |-> (ack_vec_o == $past(base_q) + (ADDR_W'(ack_id_o) << VEC_SHIFT)));
    // R10
    ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !cpu_irq_o) |=> ($stable(ack_id_o) && $stable(ack_vec_o)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int N  = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req_i = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          ack_i = 1'b0;
    logic          cpu_irq_o;
    logic [2:0]    ack_id_o;
    logic [AW-1:0] ack_vec_o;

    int total = 0;
    int bad = 0;
    logic [AW-1:0] base_m = '0;

    typedef struct packed {
        logic [2:0]    id;
        logic [AW-1:0] vec;
        logic [7:0]    tag;
    } exp_t;
    exp_t exp_q[$];
    logic ack_seen = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ack_i(ack_i),
        .cpu_irq_o(cpu_irq_o), .ack_id_o(ack_id_o), .ack_vec_o(ack_vec_o)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd1) base_m = d;
    endtask

    task automatic pulse(input logic [N-1:0] lines);
        irq_req_i = lines;
        @(negedge clk);
        irq_req_i = '0;
    endtask

    // Driver: push the expected result, then acknowledge.
    task automatic do_ack(input logic [2:0] id, input logic [7:0] tag);
        exp_t e;
        e.id = id; e.vec = base_m + (AW'(id) << 4); e.tag = tag;
        exp_q.push_back(e);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    // Monitor: record accepted acknowledges and compare after the edge.
    always @(posedge clk) ack_seen <= ack_i && cpu_irq_o && rst_n;
    always @(negedge clk) begin
        if (ack_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 unexpected ack actual=%0h expected=none", ack_id_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check($sformatf("R%0d id", e.tag), AW'(ack_id_o), AW'(e.id));
                check("R5 vec", ack_vec_o, e.vec);
            end
        end
    end

    initial begin
        #(5 * 20000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 irq", AW'(cpu_irq_o), 0);
        check("R1 id", AW'(ack_id_o), 0);
        check("R1 vec", ack_vec_o, 0);
        irq_req_i = 8'h01; cyc(4); irq_req_i = '0; cyc(1);
        check("R1 mask/en zero", AW'(cpu_irq_o), 0);
        // flush pending bit 0 through an ack later
        cfg(2'd1, 32'h1000);
        cfg(2'd0, 32'hFF);
        cfg(2'd2, 32'h1);
        check("R1 pending kept", AW'(cpu_irq_o), 1);
        do_ack(3'd0, 8'd1);
        cfg(2'd3, 0);

        // R2 synchronizer latency
        irq_req_i = 8'h10;
        cyc(2);
        check("R2 low after two edges", AW'(cpu_irq_o), 0);
        cyc(1);
        check("R2 high after third edge", AW'(cpu_irq_o), 1);
        irq_req_i = '0;
        cyc(2);
        do_ack(3'd4, 8'd5);
        cfg(2'd3, 0);
        check("R5 pending cleared", AW'(cpu_irq_o), 0);

        // R4 and R11: simultaneous single-cycle pulses
        pulse(8'h44);
        cyc(4);
        check("R11 pulse held", AW'(cpu_irq_o), 1);
        do_ack(3'd2, 8'd4);
        cfg(2'd3, 0);
        cfg(2'd1, 32'h2000);
        do_ack(3'd6, 8'd4);
        cfg(2'd3, 0);

        // R3 masked request stays pending
        cfg(2'd0, 32'hDF);
        pulse(8'h20);
        cyc(4);
        check("R3 masked no irq", AW'(cpu_irq_o), 0);
        cfg(2'd0, 32'hFF);
        check("R3 unmasked irq", AW'(cpu_irq_o), 1);
        do_ack(3'd5, 8'd3);
        cfg(2'd3, 0);

        // R6 global disable
        cfg(2'd2, 32'h0);
        pulse(8'h80);
        cyc(4);
        check("R6 disabled no irq", AW'(cpu_irq_o), 0);
        cfg(2'd2, 32'h1);
        check("R6 re-enabled irq", AW'(cpu_irq_o), 1);
        do_ack(3'd7, 8'd6);
        cfg(2'd3, 0);

        // R7 R8 R9 nesting
        pulse(8'h08);
        cyc(4);
        do_ack(3'd3, 8'd8);
        pulse(8'h20);
        cyc(4);
        check("R7 lower blocked", AW'(cpu_irq_o), 0);
        pulse(8'h08);
        cyc(4);
        check("R7 equal blocked", AW'(cpu_irq_o), 0);
        pulse(8'h02);
        cyc(4);
        check("R8 higher preempts", AW'(cpu_irq_o), 1);
        do_ack(3'd1, 8'd8);
        check("R8 blocked after nest", AW'(cpu_irq_o), 0);
        cfg(2'd3, 0);
        check("R9 first eoi keeps level 3", AW'(cpu_irq_o), 0);
        cfg(2'd3, 0);
        check("R9 second eoi releases", AW'(cpu_irq_o), 1);
        do_ack(3'd3, 8'd9);
        cfg(2'd3, 0);
        check("R9 lower next", AW'(cpu_irq_o), 1);
        do_ack(3'd5, 8'd9);
        cfg(2'd3, 0);
        check("R9 all drained", AW'(cpu_irq_o), 0);

        // R10 ack while idle is ignored
        ack_i = 1'b1; cyc(1); ack_i = 1'b0; cyc(1);
        check("R10 id kept", AW'(ack_id_o), 5);
        check("R10 vec kept", ack_vec_o, 32'h2050);
        pulse(8'h40);
        cyc(4);
        check("R10 isr untouched", AW'(cpu_irq_o), 1);
        do_ack(3'd6, 8'd10);
        cfg(2'd3, 0);

        cyc(2);
        check("R5 queue drained", AW'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule